// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one load at a time, whether the load's bytes can be taken from an older store that is still waiting in the store queue. The load presents its address, its size in bytes, the store-queue slot that was next to be filled when the load was allocated, its load-queue slot and its age tag. The checker then walks the store queue one entry per cycle from the slot just below the recorded one toward older entries, wrapping from slot 0 to the top slot, and stops after the entry at the store writeback pointer. The nearest store that touches the load's bytes decides the result.

There are three outcomes. If one store holds every byte of the load, the bytes are shifted out of that store's data and returned. If a store holds only some of the bytes, the load cannot complete and must be replayed later. If no store touches the load, the load goes to memory. For partial overlaps the block keeps a single stall record that names the oldest stalled load and the store it waits for. When that store reports that its writeback is complete, the record clears and a replay request for the recorded load is issued. Store entries are written through a simple write port that holds up to 16 data bytes per entry.

Top module: `sfwd_unit`

## Requirements
- R1: After reset the block is idle: `busy`, `res_done`, `stall_active` and `replay_req` are all 0.
- R2: A search examines slots `ld_sq_idx-1`, `ld_sq_idx-2`, … modulo the queue depth, and the last slot it examines is `sq_wb_ptr`. When `ld_sq_idx` equals `sq_wb_ptr`, no slot is examined. The nearest examined store that touches the load decides the result, even when an older store would fully cover it. `res_idx` gives the deciding slot.
- R3: Entries whose size is 0, or whose uncacheable flag is set, are skipped as if absent.
- R4: Full containment means that both store address ≤ load address and load address + load size ≤ store address + store size hold. It gives `res_code` = 2'b01. `res_data` byte b (bits 8b+7:8b) then equals store data byte (load address − store address + b) for b below the load size, and is 0 above it.
- R5: Any other intersection of the two byte ranges gives `res_code` = 2'b10 (stall), and the load is not completed.
- R6: When no examined store touches the load, `res_code` is 2'b00 (go to memory).
- R7: `res_done` is a one-cycle pulse that carries `res_code`, `res_data` and `res_idx`. A load is accepted on the clock edge that samples `ld_req` while the block is idle. When the first examined slot decides the result, `res_done` is high after the next edge.
- R8: A store write whose size exceeds 16 bytes is rejected and leaves the entry unchanged. A size of 0 leaves the slot empty.
- R9: A stall result is recorded (store age tag in `stall_st_seq`, load slot in `stall_lq_idx`) if no stall is active, or if the load's age tag is smaller (older) than that of the recorded load. Otherwise the record is unchanged.
- R10: When `st_wb_done` is high and `st_wb_seq` equals the recorded store's tag, `stall_active` falls on that edge and `replay_req` is high for one cycle, with `replay_lq_idx` set to the recorded load slot. A tag that does not match has no effect.
- R11: A `ld_req` presented while `busy` is 1 is ignored. The search in progress and its result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_wr_en | input | 1 | Write a store entry |
| st_wr_idx | input | 4 | Slot to write |
| st_wr_addr | input | 16 | Store byte address |
| st_wr_size | input | 5 | Store size in bytes (0 = empty) |
| st_wr_nc | input | 1 | Store is uncacheable |
| st_wr_seq | input | 8 | Store age tag |
| st_wr_data | input | 128 | Store data, byte 0 in bits 7:0 |
| sq_wb_ptr | input | 4 | Oldest store not yet written back |
| ld_req | input | 1 | Start a search |
| ld_addr | input | 16 | Load byte address |
| ld_size | input | 5 | Load size in bytes |
| ld_sq_idx | input | 4 | Store slot recorded at load allocation |
| ld_lq_idx | input | 4 | Load-queue slot of the load |
| ld_seq | input | 8 | Load age tag (smaller is older) |
| st_wb_done | input | 1 | A store finished writeback |
| st_wb_seq | input | 8 | Age tag of that store |
| busy | output | 1 | Search in progress |
| res_done | output | 1 | Result strobe |
| res_code | output | 2 | 00 memory, 01 forward, 10 stall |
| res_data | output | 128 | Forwarded bytes |
| res_idx | output | 4 | Deciding slot |
| stall_active | output | 1 | Stall record valid |
| stall_st_seq | output | 8 | Store tag the stall waits for |
| stall_lq_idx | output | 4 | Recorded stalled load slot |
| replay_req | output | 1 | Replay pulse |
| replay_lq_idx | output | 4 | Load slot to replay |

## Verification
The hardest case to reach from the ports is a stall record being replaced. This needs a stall already held for a young load, then a second partial-overlap load that carries an older age tag, and then a third, younger one that must leave the record alone. The stimulus gets there by letting the vector table create the first stall with increasing age tags. Directed loads with chosen tags then target a partly overlapping pair of stores. Wrap-around is reached by moving the writeback pointer near the top of the queue, so that the search crosses slot 0. A store placed just below the pointer checks that the search stops in time.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  typedef enum logic [1:0] {
    RES_MEM   = 2'b00,
    RES_FWD   = 2'b01,
    RES_STALL = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    CL_NONE = 2'b00,
    CL_FULL = 2'b01,
    CL_PART = 2'b10
  } cls_e;
endpackage

// File: rtl/sfwd_store_array.sv
module sfwd_store_array #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int MAXB   = 16,
  parameter int SEQ_W  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SIZE_W = $clog2(MAXB) + 1,
  localparam int DATA_W = 8 * MAXB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_nc,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SIZE_W-1:0] rd_size,
  output logic              rd_nc,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [SIZE_W-1:0] ent_size [DEPTH];
  logic              ent_nc   [DEPTH];
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  logic wr_take;
  assign wr_take = wr_en && (wr_size <= SIZE_W'(MAXB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_size[i] <= '0;
        ent_nc[i]   <= 1'b0;
      end
    end else if (wr_take) begin
      ent_size[wr_idx] <= wr_size;
      ent_nc[wr_idx]   <= wr_nc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) begin
      ent_addr[wr_idx] <= wr_addr;
      ent_seq[wr_idx]  <= wr_seq;
      ent_data[wr_idx] <= wr_data;
    end
  end

  assign rd_addr = ent_addr[rd_idx];
  assign rd_size = ent_size[rd_idx];
  assign rd_nc   = ent_nc[rd_idx];
  assign rd_seq  = ent_seq[rd_idx];
  assign rd_data = ent_data[rd_idx];

  // R8: an oversized store leaves the slot's size untouched
  assert_reject_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size > SIZE_W'(MAXB)) |=>
      (ent_size[$past(wr_idx)] == $past(ent_size[wr_idx])));
endmodule

// File: rtl/sfwd_scan.sv
module sfwd_scan
  import sfwd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int MAXB   = 16,
  parameter int SEQ_W  = 8,
  parameter int LQ_W   = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SIZE_W = $clog2(MAXB) + 1,
  localparam int DATA_W = 8 * MAXB,
  localparam int AW1    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [IDX_W-1:0]  ld_sq_idx,
  input  logic [LQ_W-1:0]   ld_lq_idx,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [IDX_W-1:0]  wb_ptr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic              rd_nc,
  input  logic [SEQ_W-1:0]  rd_seq,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              res_done,
  output logic [1:0]        res_code,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_idx,
  output logic              ev_stall,
  output logic [SEQ_W-1:0]  ev_st_seq,
  output logic [LQ_W-1:0]   ev_lq_idx,
  output logic [SEQ_W-1:0]  ev_ld_seq
);
  function automatic cls_e classify(input logic [ADDR_W-1:0] la, input logic [SIZE_W-1:0] ls,
                                    input logic [ADDR_W-1:0] sa, input logic [SIZE_W-1:0] ss);
    logic [AW1-1:0] l_lo, l_hi, s_lo, s_hi;
    l_lo = {1'b0, la};
    s_lo = {1'b0, sa};
    l_hi = l_lo + AW1'(ls);
    s_hi = s_lo + AW1'(ss);
    if (l_lo >= s_lo && l_hi <= s_hi) return CL_FULL;
    if (l_lo < s_hi && l_hi > s_lo)   return CL_PART;
    return CL_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] pick_bytes(input logic [DATA_W-1:0] d,
                                                   input logic [ADDR_W-1:0] off,
                                                   input logic [SIZE_W-1:0] n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < MAXB; b++) begin
      if (b < int'(n) && (b + int'(off)) < MAXB)
        r[8*b +: 8] = d[8*(b + int'(off)) +: 8];
    end
    return r;
  endfunction

  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [SIZE_W-1:0] cap_size;
  logic [LQ_W-1:0]   cap_lq;
  logic [SEQ_W-1:0]  cap_seq;

  logic              at_end, skip, hit_full;
  logic [IDX_W-1:0]  nxt;
  cls_e              cls;

  always_comb begin
    at_end   = (cur_q == wb_ptr);
    nxt      = cur_q - IDX_W'(1);
    skip     = (rd_size == '0) || rd_nc;
    cls      = classify(cap_addr, cap_size, rd_addr, rd_size);
    hit_full = busy_q && !at_end && !skip && (cls == CL_FULL);
    ev_stall = busy_q && !at_end && !skip && (cls == CL_PART);
  end

  assign rd_idx    = nxt;
  assign ev_st_seq = rd_seq;
  assign ev_lq_idx = cap_lq;
  assign ev_ld_seq = cap_seq;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      cap_addr <= '0;
      cap_size <= '0;
      cap_lq   <= '0;
      cap_seq  <= '0;
      res_done <= 1'b0;
      res_code <= RES_MEM;
      res_data <= '0;
      res_idx  <= '0;
    end else begin
      res_done <= 1'b0;
      if (!busy_q) begin
        if (ld_req) begin
          busy_q   <= 1'b1;
          cur_q    <= ld_sq_idx;
          cap_addr <= ld_addr;
          cap_size <= ld_size;
          cap_lq   <= ld_lq_idx;
          cap_seq  <= ld_seq;
        end
      end else if (at_end) begin
        busy_q   <= 1'b0;
        res_done <= 1'b1;
        res_code <= RES_MEM;
        res_data <= '0;
        res_idx  <= cur_q;
      end else if (hit_full) begin
        busy_q   <= 1'b0;
        res_done <= 1'b1;
        res_code <= RES_FWD;
        res_data <= pick_bytes(rd_data, cap_addr - rd_addr, cap_size);
        res_idx  <= nxt;
      end else if (ev_stall) begin
        busy_q   <= 1'b0;
        res_done <= 1'b1;
        res_code <= RES_STALL;
        res_data <= '0;
        res_idx  <= nxt;
      end else begin
        cur_q <= nxt;
      end
    end
  end

  // R7: result strobe lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  // R4/R5/R6: only the three defined result codes appear
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_code != 2'b11));
  // R11: a request while busy does not disturb the captured load
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ld_req) |=> ($stable(cap_addr) && $stable(cap_seq)));
  // R7: search starts only from an accepted request
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ld_req));
endmodule

// File: rtl/sfwd_stall_rec.sv
module sfwd_stall_rec #(
  parameter int SEQ_W = 8,
  parameter int LQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_stall,
  input  logic [SEQ_W-1:0] ev_st_seq,
  input  logic [LQ_W-1:0]  ev_lq_idx,
  input  logic [SEQ_W-1:0] ev_ld_seq,
  input  logic             wb_done,
  input  logic [SEQ_W-1:0] wb_seq,
  output logic             stall_active,
  output logic [SEQ_W-1:0] stall_st_seq,
  output logic [LQ_W-1:0]  stall_lq_idx,
  output logic             replay_req,
  output logic [LQ_W-1:0]  replay_lq_idx
);
  logic             act_q;
  logic [SEQ_W-1:0] st_seq_q, ld_seq_q;
  logic [LQ_W-1:0]  lq_q;
  logic             clr_hit, act_eff, take;

  always_comb begin
    clr_hit = act_q && wb_done && (wb_seq == st_seq_q);
    act_eff = act_q && !clr_hit;
    take    = ev_stall && (!act_eff || (ev_ld_seq < ld_seq_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q         <= 1'b0;
      st_seq_q      <= '0;
      ld_seq_q      <= '0;
      lq_q          <= '0;
      replay_req    <= 1'b0;
      replay_lq_idx <= '0;
    end else begin
      replay_req <= clr_hit;
      if (clr_hit) replay_lq_idx <= lq_q;
      if (take) begin
        act_q    <= 1'b1;
        st_seq_q <= ev_st_seq;
        ld_seq_q <= ev_ld_seq;
        lq_q     <= ev_lq_idx;
      end else if (clr_hit) begin
        act_q <= 1'b0;
      end
    end
  end

  assign stall_active = act_q;
  assign stall_st_seq = st_seq_q;
  assign stall_lq_idx = lq_q;

  // R9: a stall record only appears from a stall event
  assert_stall_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(ev_stall));
  // R9: a younger stalled load keeps the existing record
  assert_keep_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall && act_q && !clr_hit && ev_ld_seq >= ld_seq_q) |=> $stable(lq_q));
  // R10: a replay follows an active record
  assert_replay_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> $past(act_q));
endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int MAXB   = 16,
  parameter int SEQ_W  = 8,
  parameter int LQ_W   = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SIZE_W = $clog2(MAXB) + 1,
  localparam int DATA_W = 8 * MAXB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr_en,
  input  logic [IDX_W-1:0]  st_wr_idx,
  input  logic [ADDR_W-1:0] st_wr_addr,
  input  logic [SIZE_W-1:0] st_wr_size,
  input  logic              st_wr_nc,
  input  logic [SEQ_W-1:0]  st_wr_seq,
  input  logic [DATA_W-1:0] st_wr_data,
  input  logic [IDX_W-1:0]  sq_wb_ptr,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [IDX_W-1:0]  ld_sq_idx,
  input  logic [LQ_W-1:0]   ld_lq_idx,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic              st_wb_done,
  input  logic [SEQ_W-1:0]  st_wb_seq,
  output logic              busy,
  output logic              res_done,
  output logic [1:0]        res_code,
  output logic [DATA_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_idx,
  output logic              stall_active,
  output logic [SEQ_W-1:0]  stall_st_seq,
  output logic [LQ_W-1:0]   stall_lq_idx,
  output logic              replay_req,
  output logic [LQ_W-1:0]   replay_lq_idx
);
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [SIZE_W-1:0] rd_size;
  logic              rd_nc;
  logic [SEQ_W-1:0]  rd_seq;
  logic [DATA_W-1:0] rd_data;
  logic              ev_stall;
  logic [SEQ_W-1:0]  ev_st_seq, ev_ld_seq;
  logic [LQ_W-1:0]   ev_lq_idx;

  sfwd_store_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAXB(MAXB), .SEQ_W(SEQ_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_addr(st_wr_addr), .wr_size(st_wr_size),
    .wr_nc(st_wr_nc), .wr_seq(st_wr_seq), .wr_data(st_wr_data),
    .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_size(rd_size), .rd_nc(rd_nc),
    .rd_seq(rd_seq), .rd_data(rd_data)
  );

  sfwd_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAXB(MAXB), .SEQ_W(SEQ_W), .LQ_W(LQ_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size), .ld_sq_idx(ld_sq_idx),
    .ld_lq_idx(ld_lq_idx), .ld_seq(ld_seq), .wb_ptr(sq_wb_ptr),
    .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_size(rd_size), .rd_nc(rd_nc),
    .rd_seq(rd_seq), .rd_data(rd_data),
    .busy(busy), .res_done(res_done), .res_code(res_code), .res_data(res_data),
    .res_idx(res_idx),
    .ev_stall(ev_stall), .ev_st_seq(ev_st_seq), .ev_lq_idx(ev_lq_idx), .ev_ld_seq(ev_ld_seq)
  );

  sfwd_stall_rec #(.SEQ_W(SEQ_W), .LQ_W(LQ_W)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .ev_stall(ev_stall), .ev_st_seq(ev_st_seq), .ev_lq_idx(ev_lq_idx), .ev_ld_seq(ev_ld_seq),
    .wb_done(st_wb_done), .wb_seq(st_wb_seq),
    .stall_active(stall_active), .stall_st_seq(stall_st_seq), .stall_lq_idx(stall_lq_idx),
    .replay_req(replay_req), .replay_lq_idx(replay_lq_idx)
  );
endmodule

// File: tb/tb_sfwd_unit.sv
module tb_sfwd_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         st_wr_en, st_wr_nc;
  logic [3:0]   st_wr_idx;
  logic [15:0]  st_wr_addr;
  logic [4:0]   st_wr_size;
  logic [7:0]   st_wr_seq;
  logic [127:0] st_wr_data;
  logic [3:0]   sq_wb_ptr;
  logic         ld_req;
  logic [15:0]  ld_addr;
  logic [4:0]   ld_size;
  logic [3:0]   ld_sq_idx, ld_lq_idx;
  logic [7:0]   ld_seq;
  logic         st_wb_done;
  logic [7:0]   st_wb_seq;
  logic         busy, res_done, stall_active, replay_req;
  logic [1:0]   res_code;
  logic [127:0] res_data;
  logic [3:0]   res_idx, stall_lq_idx, replay_lq_idx;
  logic [7:0]   stall_st_seq;

  sfwd_unit dut (.*);

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [15:0] a;
    logic [4:0]  sz;
    logic [3:0]  sq;
    logic [1:0]  code;
    logic [3:0]  idx;
    logic [3:0]  sh;
  } vec_t;

  // write pointer = 2 for the whole table
  localparam vec_t VEC [10] = '{
    '{16'h0102, 5'd4,  4'd8, 2'd1, 4'd2, 4'd2},   // R4 full, shifted
    '{16'h0200, 5'd16, 4'd8, 2'd1, 4'd3, 4'd0},   // R4 full width
    '{16'h0108, 5'd4,  4'd8, 2'd0, 4'd0, 4'd0},   // R3 uncacheable skipped, R6
    '{16'h0106, 5'd4,  4'd8, 2'd2, 4'd2, 4'd0},   // R5 partial
    '{16'h0403, 5'd2,  4'd8, 2'd1, 4'd7, 4'd1},   // R2 nearest full wins
    '{16'h0400, 5'd4,  4'd8, 2'd2, 4'd7, 4'd0},   // R2 nearest partial wins
    '{16'h0400, 5'd4,  4'd7, 2'd1, 4'd6, 4'd0},   // R2 start below recorded slot
    '{16'h0102, 5'd4,  4'd2, 2'd0, 4'd0, 4'd0},   // R2 start == write pointer
    '{16'h0300, 5'd1,  4'd8, 2'd0, 4'd0, 4'd0},   // R3 size-zero skipped
    '{16'h0100, 5'd8,  4'd3, 2'd1, 4'd2, 4'd0}    // R4 exact
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_bytes(input int slot, input int sh, input int n);
    logic [127:0] v = '0;
    for (int b = 0; b < n; b++) v[8*b +: 8] = 8'(slot * 16 + sh + b);
    return v;
  endfunction

  task automatic put_store(input int slot, input logic [15:0] a, input int sz, input logic nc);
    @(negedge clk);
    st_wr_en   = 1'b1;
    st_wr_idx  = 4'(slot);
    st_wr_addr = a;
    st_wr_size = 5'(sz);
    st_wr_nc   = nc;
    st_wr_seq  = 8'(10 + slot);
    for (int j = 0; j < 16; j++) st_wr_data[8*j +: 8] = 8'(slot * 16 + j);
    @(negedge clk);
    st_wr_en = 1'b0;
  endtask

  logic [1:0]   g_code;
  logic [3:0]   g_idx;
  logic [127:0] g_data;
  logic         g_ok;

  task automatic run_load(input logic [15:0] a, input int sz, input int sq, input int lq, input int seq);
    @(negedge clk);
    ld_req = 1'b1; ld_addr = a; ld_size = 5'(sz); ld_sq_idx = 4'(sq);
    ld_lq_idx = 4'(lq); ld_seq = 8'(seq);
    @(negedge clk);
    ld_req = 1'b0;
    g_ok = 1'b0;
    for (int t = 0; t < 40 && !g_ok; t++) begin
      @(negedge clk);
      if (res_done) begin
        g_ok = 1'b1; g_code = res_code; g_idx = res_idx; g_data = res_data;
      end
    end
  endtask

  task automatic wb_notify(input logic [7:0] s);
    @(negedge clk);
    st_wb_done = 1'b1; st_wb_seq = s;
    @(negedge clk);
    st_wb_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_wr_en = 0; st_wr_idx = 0; st_wr_addr = 0; st_wr_size = 0;
    st_wr_nc = 0; st_wr_seq = 0; st_wr_data = '0; sq_wb_ptr = 4'd2; ld_req = 0;
    ld_addr = 0; ld_size = 0; ld_sq_idx = 0; ld_lq_idx = 0; ld_seq = 0;
    st_wb_done = 0; st_wb_seq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 128'(busy), 128'd0);
    check("R1 done", 128'(res_done), 128'd0);
    check("R1 stall", 128'(stall_active), 128'd0);
    check("R1 replay", 128'(replay_req), 128'd0);

    put_store(2, 16'h0100, 8, 1'b0);
    put_store(3, 16'h0200, 16, 1'b0);
    put_store(4, 16'h0108, 4, 1'b1);
    put_store(5, 16'h0300, 0, 1'b0);
    put_store(6, 16'h0400, 4, 1'b0);
    put_store(7, 16'h0402, 4, 1'b0);

    for (int v = 0; v < 10; v++) begin
      run_load(VEC[v].a, int'(VEC[v].sz), int'(VEC[v].sq), v, 100 + v);
      check($sformatf("R7 done v%0d", v), 128'(g_ok), 128'd1);
      check($sformatf("R4/R5/R6 code v%0d", v), 128'(g_code), 128'(VEC[v].code));
      if (VEC[v].code != 2'd0) check($sformatf("R2 idx v%0d", v), 128'(g_idx), 128'(VEC[v].idx));
      if (VEC[v].code == 2'd1)
        check($sformatf("R4 data v%0d", v), g_data,
              exp_bytes(int'(VEC[v].idx), int'(VEC[v].sh), int'(VEC[v].sz)));
    end

    // R9 first stall recorded (v3), younger v5 did not replace
    check("R9 active", 128'(stall_active), 128'd1);
    check("R9 lq first", 128'(stall_lq_idx), 128'd3);
    check("R9 st seq first", 128'(stall_st_seq), 128'd12);

    // R9 older load replaces the record
    run_load(16'h0400, 4, 8, 9, 20);
    check("R9 older code", 128'(g_code), 128'd2);
    check("R9 older lq", 128'(stall_lq_idx), 128'd9);
    check("R9 older st seq", 128'(stall_st_seq), 128'd17);
    // R9 younger load leaves the record
    run_load(16'h0106, 4, 8, 6, 200);
    check("R9 younger code", 128'(g_code), 128'd2);
    check("R9 younger lq", 128'(stall_lq_idx), 128'd9);

    // R10 non-matching tag has no effect
    wb_notify(8'd12);
    check("R10 nomatch replay", 128'(replay_req), 128'd0);
    check("R10 nomatch stall", 128'(stall_active), 128'd1);
    // R10 matching tag clears and pulses replay
    @(negedge clk);
    st_wb_done = 1'b1; st_wb_seq = 8'd17;
    @(negedge clk);
    st_wb_done = 1'b0;
    check("R10 replay", 128'(replay_req), 128'd1);
    check("R10 replay lq", 128'(replay_lq_idx), 128'd9);
    check("R10 cleared", 128'(stall_active), 128'd0);
    @(negedge clk);
    check("R10 replay pulse", 128'(replay_req), 128'd0);

    // R8 oversize store rejected
    put_store(9, 16'h0700, 17, 1'b0);
    run_load(16'h0700, 4, 10, 1, 30);
    check("R8 rejected", 128'(g_code), 128'd0);
    put_store(9, 16'h0700, 16, 1'b0);
    run_load(16'h0704, 4, 10, 1, 31);
    check("R8 accepted code", 128'(g_code), 128'd1);
    check("R8 accepted data", g_data, exp_bytes(9, 4, 4));

    // R7 exact timing: first examined slot decides
    @(negedge clk);
    ld_req = 1'b1; ld_addr = 16'h0100; ld_size = 5'd8; ld_sq_idx = 4'd3; ld_seq = 8'd40;
    @(negedge clk);
    ld_req = 1'b0;
    check("R7 busy after accept", 128'(busy), 128'd1);
    check("R7 no early done", 128'(res_done), 128'd0);
    @(negedge clk);
    check("R7 done next edge", 128'(res_done), 128'd1);
    check("R7 fwd code", 128'(res_code), 128'd1);
    @(negedge clk);
    check("R7 done pulse", 128'(res_done), 128'd0);

    // R11 request while busy ignored
    @(negedge clk);
    ld_req = 1'b1; ld_addr = 16'h0100; ld_size = 5'd8; ld_sq_idx = 4'd8; ld_seq = 8'd41;
    @(negedge clk);
    ld_addr = 16'h0200; ld_size = 5'd16; ld_sq_idx = 4'd4;
    @(negedge clk);
    ld_req = 1'b0;
    g_ok = 1'b0;
    for (int t = 0; t < 40 && !g_ok; t++) begin
      @(negedge clk);
      if (res_done) begin g_ok = 1'b1; g_idx = res_idx; g_code = res_code; end
    end
    check("R11 first result idx", 128'(g_idx), 128'd2);
    check("R11 first result code", 128'(g_code), 128'd1);
    g_ok = 1'b0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (res_done) g_ok = 1'b1;
    end
    check("R11 no second result", 128'(g_ok), 128'd0);

    // R2 wrap-around below slot 0, and stop at the write pointer
    sq_wb_ptr = 4'd14;
    put_store(0, 16'h0600, 4, 1'b0);
    put_store(15, 16'h0500, 8, 1'b0);
    put_store(13, 16'h0800, 4, 1'b0);
    run_load(16'h0504, 4, 1, 2, 50);
    check("R2 wrap code", 128'(g_code), 128'd1);
    check("R2 wrap idx", 128'(g_idx), 128'd15);
    check("R2 wrap data", g_data, exp_bytes(15, 4, 4));
    run_load(16'h0800, 4, 1, 2, 51);
    check("R2 stop at pointer", 128'(g_code), 128'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule